// File: doc/BRIEF.md
# Low-Power Clock Mode Controller

This block decides when the internal clock of a small 8-bit processor core runs. An 8-bit control register chooses between halving the reference clock and passing it straight through. It also chooses one of three sleep flavours: idle, standby, and standby with a short restart. When the core reports that it has decoded a sleep instruction and the I/O-stop flag is set, the controller stops the clocks in the way the selected flavour requires. It restarts them when an enabled interrupt or a reset arrives.

In idle the oscillator keeps running and only the core and clock-out enables drop. In standby the oscillator itself is switched off. On wake-up, the oscillator is given a fixed settling interval before the core clock returns. That interval is short in the quick variant and long in the normal variant. The register can optionally allow a bus request to be granted while in standby. The grant comes only after the settling interval, and once the request is withdrawn the block goes back to standby. The three drive-reduction bits are stored and read back but have no modelled effect.

Top module: `lp_clk_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the register becomes 0x00 and the block returns to running at divide-by-two, whatever mode it was in.
- R2: When running, register bit 7 = 0 makes `core_clk_en` high on every other cycle, starting with the first running cycle. Bit 7 = 1 makes it high on every cycle.
- R3: Register bits {6,3} select the sleep flavour: 01 = idle, 10 = standby, 11 = quick standby, 00 = none. A sleep mode is entered only on `sleep_stb` with `io_stop` high and a non-zero selection. Otherwise `sleep_stb` halts the core: `sts_halt` goes high and the core clock keeps running.
- R4: In idle, `osc_run` stays 1 while `core_clk_en` and `clkout_en` are 0. `wake_irq` resumes running at the next edge.
- R5: In standby (either flavour), `osc_run`, `core_clk_en` and `clkout_en` are all 0 and `sts_stby` is 1.
- R6: After `wake_irq` in standby, `osc_run` is 1 with the core clock held off for exactly 64 cycles in quick standby, or exactly STBY_CYC cycles in normal standby. After that the core runs.
- R7: With register bit 5 = 1 and `busreq` high in standby, the oscillator restarts and `busack_ok` rises only after the same settling interval. `core_clk_en` stays 0 throughout.
- R8: With register bit 5 = 0, `busreq` has no effect in standby: the oscillator stays off and `busack_ok` stays 0.
- R9: When `busreq` drops during a grant, the block returns to standby with the oscillator stopped, and it does not run until a wake.
- R10: Register bits 7..3, 1 and 0 are read back on `reg_rdata` as written. Bit 2 always reads 0. Bits 4, 1 and 0 do not change the clock outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset, also a wake source |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register contents |
| sleep_stb | input | 1 | Sleep instruction decoded (one cycle) |
| io_stop | input | 1 | I/O-stop flag |
| wake_irq | input | 1 | Enabled interrupt pending |
| busreq | input | 1 | External bus request |
| core_clk_en | output | 1 | Core clock enable |
| clkout_en | output | 1 | Clock output enable |
| osc_run | output | 1 | Oscillator run enable |
| busack_ok | output | 1 | Bus acknowledge permitted |
| sts_halt | output | 1 | Core halted, clock running |
| sts_idle | output | 1 | In idle |
| sts_stby | output | 1 | In standby with oscillator off |

## Verification
The properties assume `sleep_stb` arrives only while the core is running. They also assume the register is not written during idle, standby, recovery or a bus grant, since a stopped core cannot issue writes. The bench writes the register only while the core runs and pulses `sleep_stb` for one cycle from the running state. It holds `busreq` steady through the recovery window so that grant timing is unambiguous.

// File: rtl/lp_clk_pkg.sv
package lp_clk_pkg;
  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_HALT  = 3'd1,
    ST_IDLE  = 3'd2,
    ST_STBY  = 3'd3,
    ST_RECOV = 3'd4,
    ST_BUS   = 3'd5
  } lp_state_t;

  typedef enum logic [1:0] {
    LP_NONE  = 2'b00,
    LP_IDLE  = 2'b01,
    LP_STBY  = 2'b10,
    LP_QUICK = 2'b11
  } lp_sel_t;

  typedef struct packed {
    logic    div1;
    lp_sel_t sel;
    logic    bus_ext;
    logic    drv_clk;
    logic    drv_ctl;
    logic    drv_ad;
  } lp_cfg_t;
endpackage

// File: rtl/lp_ctl_reg.sv
module lp_ctl_reg
  import lp_clk_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output lp_cfg_t       cfg
);
  localparam logic [DW-1:0] RSVD_MASK = DW'(8'hFB);
  logic [DW-1:0] q;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (we) q <= wdata & RSVD_MASK;
  end

  assign rdata       = q;
  assign cfg.div1    = q[7];
  assign cfg.sel     = lp_sel_t'({q[6], q[3]});
  assign cfg.bus_ext = q[5];
  assign cfg.drv_clk = q[4];
  assign cfg.drv_ctl = q[1];
  assign cfg.drv_ad  = q[0];
endmodule

// File: rtl/lp_clk_div.sv
module lp_clk_div (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic div1,
  output logic en
);
  logic tog;

  always_ff @(posedge clk) begin
    if (rst || !run) tog <= 1'b0;
    else             tog <= ~tog;
  end

  assign en = run && (div1 || !tog);
endmodule

// File: rtl/lp_recov_timer.sv
module lp_recov_timer #(
  parameter int CW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/lp_clk_ctrl.sv
module lp_clk_ctrl
  import lp_clk_pkg::*;
#(
  parameter int QUICK_CYC = 64,
  parameter int STBY_CYC  = 131072
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       sleep_stb,
  input  logic       io_stop,
  input  logic       wake_irq,
  input  logic       busreq,
  output logic       core_clk_en,
  output logic       clkout_en,
  output logic       osc_run,
  output logic       busack_ok,
  output logic       sts_halt,
  output logic       sts_idle,
  output logic       sts_stby
);
  localparam int MAXC = (STBY_CYC > QUICK_CYC) ? STBY_CYC : QUICK_CYC;
  localparam int CW   = $clog2(MAXC);

  lp_cfg_t   cfg;
  lp_state_t st, st_n;
  logic      wk_q, wk_n;
  logic      t_load, t_done, running;
  logic [CW-1:0] t_val;

  lp_ctl_reg #(.DW(8)) u_reg (
    .clk(clk), .rst(rst), .we(reg_we), .wdata(reg_wdata),
    .rdata(reg_rdata), .cfg(cfg)
  );

  assign t_val = (cfg.sel == LP_QUICK) ? CW'(QUICK_CYC - 1) : CW'(STBY_CYC - 1);

  lp_recov_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .done(t_done)
  );

  assign running = (st == ST_RUN) || (st == ST_HALT);

  lp_clk_div u_div (
    .clk(clk), .rst(rst), .run(running), .div1(cfg.div1), .en(core_clk_en)
  );

  always_comb begin
    st_n   = st;
    wk_n   = wk_q;
    t_load = 1'b0;
    unique case (st)
      ST_RUN: if (sleep_stb) begin
        if (io_stop && cfg.sel == LP_IDLE)       st_n = ST_IDLE;
        else if (io_stop && cfg.sel[1])          st_n = ST_STBY;
        else                                     st_n = ST_HALT;
      end
      ST_HALT, ST_IDLE: if (wake_irq) st_n = ST_RUN;
      ST_STBY: if (wake_irq || (busreq && cfg.bus_ext)) begin
        st_n   = ST_RECOV;
        wk_n   = wake_irq;
        t_load = 1'b1;
      end
      ST_RECOV: begin
        if (wake_irq) wk_n = 1'b1;
        if (t_done) begin
          if (wk_q || wake_irq)          st_n = ST_RUN;
          else if (busreq && cfg.bus_ext) st_n = ST_BUS;
          else                            st_n = ST_STBY;
          wk_n = 1'b0;
        end
      end
      ST_BUS: if (!busreq) st_n = ST_STBY;
      default: st_n = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_RUN;
      wk_q <= 1'b0;
    end else begin
      st   <= st_n;
      wk_q <= wk_n;
    end
  end

  assign clkout_en = running;
  assign osc_run   = (st != ST_STBY);
  assign busack_ok = (st == ST_BUS);
  assign sts_halt  = (st == ST_HALT);
  assign sts_idle  = (st == ST_IDLE);
  assign sts_stby  = (st == ST_STBY);
endmodule

// File: rtl/lp_clk_ctrl_chk.sv
module lp_clk_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] reg_rdata,
  input logic       sleep_stb,
  input logic       io_stop,
  input logic       core_clk_en,
  input logic       clkout_en,
  input logic       osc_run,
  input logic       busack_ok,
  input logic       sts_idle,
  input logic       sts_stby
);
  // R5
  stby_clocks_off_chk: assert property (@(posedge clk) disable iff (rst)
    sts_stby |-> (!osc_run && !core_clk_en && !clkout_en));

  // R4
  idle_osc_only_chk: assert property (@(posedge clk) disable iff (rst)
    sts_idle |-> (osc_run && !core_clk_en && !clkout_en));

  // R3
  idle_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(sts_idle)) |-> $past(sleep_stb && io_stop));

  // R7
  grant_core_off_chk: assert property (@(posedge clk) disable iff (rst)
    busack_ok |-> (osc_run && !core_clk_en));

  // R8
  grant_needs_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(busack_ok)) |-> $past(reg_rdata[5]));

  // R9
  release_to_stby_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(busack_ok)) |-> !osc_run);

  // R2
  div2_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !reg_rdata[7] && !$past(reg_rdata[7]) && $past(core_clk_en))
      |-> !core_clk_en);

  // R10
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[2] == 1'b0);
endmodule

bind lp_clk_ctrl lp_clk_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .reg_rdata(reg_rdata), .sleep_stb(sleep_stb),
  .io_stop(io_stop), .core_clk_en(core_clk_en), .clkout_en(clkout_en),
  .osc_run(osc_run), .busack_ok(busack_ok), .sts_idle(sts_idle),
  .sts_stby(sts_stby)
);

// File: tb/tb_lp_clk_ctrl.sv
module tb_lp_clk_ctrl;
  localparam time CLK_PERIOD = 10ns;
  localparam int  QUICK = 64;
  localparam int  NORM  = 300;

  logic clk = 1'b0, rst = 1'b1, reg_we = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic sleep_stb = 0, io_stop = 0, wake_irq = 0, busreq = 0;
  logic core_clk_en, clkout_en, osc_run, busack_ok, sts_halt, sts_idle, sts_stby;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lp_clk_ctrl #(.QUICK_CYC(QUICK), .STBY_CYC(NORM)) dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sleep_stb(sleep_stb), .io_stop(io_stop),
    .wake_irq(wake_irq), .busreq(busreq), .core_clk_en(core_clk_en),
    .clkout_en(clkout_en), .osc_run(osc_run), .busack_ok(busack_ok),
    .sts_halt(sts_halt), .sts_idle(sts_idle), .sts_stby(sts_stby)
  );

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] v);
    reg_we = 1; reg_wdata = v; step(); reg_we = 0;
  endtask

  task automatic do_sleep(logic stop);
    io_stop = stop; sleep_stb = 1; step(); sleep_stb = 0; io_stop = 0;
  endtask

  task automatic wake();
    wake_irq = 1; step(); wake_irq = 0;
  endtask

  task automatic count_ones(output int n, input int cyc);
    n = 0;
    for (int i = 0; i < cyc; i++) begin n += core_clk_en; step(); end
  endtask

  // counts cycles with oscillator on and core held off, stops at busack
  task automatic count_recov(output int n);
    n = 0;
    while (osc_run && !core_clk_en && !busack_ok && n < 1000) begin n++; step(); end
  endtask

  task automatic t_reset();
    int n;
    rst = 1; step(2); rst = 0;
    chk("R1 reg after reset", reg_rdata, 0);
    chk("R1 running", clkout_en, 1);
    count_ones(n, 10);
    chk("R1 div2 after reset", n, 5);
  endtask

  task automatic t_divider();
    int n;
    wr(8'h80);
    count_ones(n, 10);
    chk("R2 div1 every cycle", n, 10);
    wr(8'h00);
    step();
    count_ones(n, 10);
    chk("R2 div2 half", n, 5);
  endtask

  task automatic t_regs();
    int n;
    wr(8'hFF);
    chk("R10 readback bit2 zero", reg_rdata, 8'hFB);
    wr(8'h93);
    chk("R10 readback", reg_rdata, 8'h93);
    count_ones(n, 10);
    chk("R10 drive bits no effect", n, 10);
  endtask

  task automatic t_halt();
    int n;
    wr(8'h80);
    do_sleep(1);
    chk("R3 none sel halts", sts_halt, 1);
    count_ones(n, 6);
    chk("R3 halt clock runs", n, 6);
    wake();
    chk("R3 wake from halt", sts_halt, 0);
    wr(8'h88);
    do_sleep(0);
    chk("R3 no io_stop halts", sts_halt, 1);
    chk("R3 no io_stop not idle", sts_idle, 0);
    wake();
  endtask

  task automatic t_idle();
    wr(8'h88);
    do_sleep(1);
    chk("R4 idle flag", sts_idle, 1);
    chk("R4 idle osc", osc_run, 1);
    chk("R4 idle core off", core_clk_en, 0);
    chk("R4 idle clkout off", clkout_en, 0);
    step(5);
    chk("R4 still idle", sts_idle, 1);
    wake();
    chk("R4 resumes", core_clk_en, 1);
  endtask

  task automatic t_standby(logic [7:0] cfg, int exp, string tag);
    int n;
    wr(cfg);
    do_sleep(1);
    chk({tag, " R5 stby flag"}, sts_stby, 1);
    chk("R5 osc off", osc_run, 0);
    chk("R5 core off", core_clk_en, 0);
    step(20);
    chk("R5 stays stby", sts_stby, 1);
    wake();
    count_recov(n);
    chk({tag, " R6 recovery length"}, n, exp);
    chk({tag, " R6 core runs"}, core_clk_en, 1);
  endtask

  task automatic t_bus_ignored();
    wr(8'hC8);
    do_sleep(1);
    busreq = 1;
    step(100);
    chk("R8 osc stays off", osc_run, 0);
    chk("R8 no grant", busack_ok, 0);
    busreq = 0;
    wake();
    step(QUICK + 2);
  endtask

  task automatic t_bus_grant();
    int n;
    wr(8'hE8);
    do_sleep(1);
    busreq = 1;
    step();
    count_recov(n);
    chk("R7 grant delay", n, QUICK);
    chk("R7 granted", busack_ok, 1);
    chk("R7 core off in grant", core_clk_en, 0);
    step(10);
    chk("R7 grant held", busack_ok, 1);
    busreq = 0;
    step();
    chk("R9 back to stby", sts_stby, 1);
    chk("R9 osc off", osc_run, 0);
    chk("R9 grant dropped", busack_ok, 0);
    step(10);
    chk("R9 no resume", core_clk_en, 0);
    wake();
    count_recov(n);
    chk("R9 wake after grant", n, QUICK);
  endtask

  task automatic t_reset_exit();
    wr(8'hC0);
    do_sleep(1);
    chk("R1 in stby before rst", sts_stby, 1);
    rst = 1; step(); rst = 0;
    chk("R1 rst exits stby", clkout_en, 1);
    chk("R1 rst clears reg", reg_rdata, 0);
  endtask

  initial begin
    step();
    t_reset();
    t_divider();
    t_regs();
    t_halt();
    t_idle();
    t_standby(8'hC8, QUICK, "quick");
    t_standby(8'hC0, NORM, "normal");
    t_bus_ignored();
    t_bus_grant();
    t_reset_exit();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule